// File: doc/BRIEF.md
# Watchdog and Interval Timer

This block is an 8-bit up-counter driven by a free-running prescaler. Software picks one of eight count rates and one of two uses for it. In interval use, each counter wrap sets a sticky overflow flag, and the flag raises a level interrupt request to the processor. In watchdog use, software has to keep reloading the counter before it wraps. A wrap produces a one-clock overflow pulse and, when built in, a one-clock internal reset request.

Software reaches two registers through a simple bus with read and write strobes, an address bit and a 16-bit write word. Address 0 is the control/status register and address 1 is the counter. Every write carries a key in its upper byte and the new value in its lower byte. A write with the wrong key is dropped, so a stray store cannot stop the watchdog. The overflow flag can only be cleared by a write of zero to it that comes after a read which saw it set.

Top module: `wdog_itimer`

## Requirements
- R1: After reset the control/status register reads 0x18, the counter reads 0x00, and irq_o, wdt_ovf_o and rst_req_o are all low.
- R2: Control/status layout: bit 7 is the overflow flag, bit 6 is the mode (0 interval, 1 watchdog), bit 5 is the enable, bits 4 and 3 always read 1, and bits 2..0 are the rate code. A write to address 0 updates mode, enable and rate only when wdata[15:8] is 0xA5. A write with any other key leaves the whole register unchanged.
- R3: A write to address 1 with wdata[15:8] equal to 0x5A loads wdata[7:0] into the counter. A write with any other key, or any load while enable is 0, leaves the counter unchanged.
- R4: While enable is 0 the counter is forced to 0x00 and held there, starting the cycle after enable reads 0. While enable is 1 it increments by one on each rate tick.
- R5: Rate codes 0..7 give one count tick every 2, 64, 128, 512, 2048, 8192, 32768 and 131072 clocks. The tick is the rising edge of the selected bit of a free-running 17-bit prescaler.
- R6: A tick that takes the counter from 0xFF to 0x00 sets the overflow flag. A load never sets it.
- R7: The flag clears only on a keyed write to address 0 with bit 7 = 0 that comes after a read of address 0 which returned bit 7 = 1. Writing 1 to bit 7, or writing 0 without such a prior read, leaves the flag set.
- R8: irq_o is high in the cycle after one in which the flag is 1 and the mode is interval, and is low otherwise.
- R9: In watchdog mode each overflow gives a wdt_ovf_o pulse exactly one clock wide, one cycle after the wrapping tick.
- R10: With the reset-request option on, rst_req_o pulses together with wdt_ovf_o, and the overflow flag reads 0 again from the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 1 | Register select: 0 control/status, 1 counter |
| wdata | input | 16 | Write word: key in [15:8], value in [7:0] |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| rdata | output | 8 | Read data, registered, valid the cycle after rd_en |
| irq_o | output | 1 | Interval interrupt request (level) |
| wdt_ovf_o | output | 1 | Watchdog overflow pulse |
| rst_req_o | output | 1 | Internal reset request pulse |

## Verification
A wrong prescaler tap or a bad tick edge shows up as a wrong increment spacing of the counter. Polling the counter every cycle exposes it within one tick period of the selected rate. A corrupted flag or arm state shows up at irq_o one cycle later, or as a read value with the wrong bit 7 on the next status read. A lost or doubled overflow shows up as a wdt_ovf_o or rst_req_o pulse on the wrong cycle. The bench runs a behavioural model alongside the design and compares every output on every clock, so any divergence is reported in the cycle it first reaches a port.

// File: rtl/wdog_pkg.sv
package wdog_pkg;
  localparam int PRE_W  = 17;
  localparam int TAP_IW = $clog2(PRE_W);
  localparam int KEY_W  = 8;
  localparam logic [KEY_W-1:0] KEY_CSR = 8'hA5;
  localparam logic [KEY_W-1:0] KEY_CNT = 8'h5A;

  // prescaler bit whose rising edge forms the count tick for each rate code
  function automatic logic [TAP_IW-1:0] tap_index(input logic [2:0] code);
    logic [TAP_IW-1:0] t;
    case (code)
      3'd0: t = TAP_IW'(0);
      3'd1: t = TAP_IW'(5);
      3'd2: t = TAP_IW'(6);
      3'd3: t = TAP_IW'(8);
      3'd4: t = TAP_IW'(10);
      3'd5: t = TAP_IW'(12);
      3'd6: t = TAP_IW'(14);
      default: t = TAP_IW'(16);
    endcase
    return t;
  endfunction
endpackage

// File: rtl/wdog_prescaler.sv
module wdog_prescaler
  import wdog_pkg::*;
#(
  parameter int W = PRE_W
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [2:0] rate,
  output logic       tick
);
  logic [W-1:0] pre_q;
  logic         sel_bit;
  logic         prev_q;

  assign sel_bit = pre_q[tap_index(rate)];
  assign tick    = sel_bit & ~prev_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre_q  <= '0;
      prev_q <= 1'b0;
    end else begin
      pre_q  <= pre_q + 1'b1;
      prev_q <= sel_bit;
    end
  end
endmodule

// File: rtl/wdog_counter.sv
module wdog_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             ld,
  input  logic [CNT_W-1:0] ld_val,
  input  logic             tick,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assign wrap_o = en & tick & ~ld & (cnt_o == CNT_MAX);

  always_ff @(posedge clk) begin
    if (rst || !en)
      cnt_o <= '0;
    else if (ld)
      cnt_o <= ld_val;
    else if (tick)
      cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/wdog_csr.sv
module wdog_csr (
  input  logic       clk,
  input  logic       rst,
  input  logic       csr_rd,
  input  logic       csr_wr,
  input  logic [7:0] wr_byte,
  input  logic       wrap,
  input  logic       auto_clr,
  output logic       flag_o,
  output logic       mode_o,
  output logic       en_o,
  output logic [2:0] rate_o,
  output logic [7:0] csr_val
);
  logic armed_q;
  logic sw_clr;

  assign csr_val = {flag_o, mode_o, en_o, 2'b11, rate_o};
  assign sw_clr  = csr_wr & ~wr_byte[7] & armed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_o  <= 1'b0;
      mode_o  <= 1'b0;
      en_o    <= 1'b0;
      rate_o  <= 3'd0;
      armed_q <= 1'b0;
    end else begin
      if (wrap)
        flag_o <= 1'b1;
      else if (auto_clr || sw_clr)
        flag_o <= 1'b0;

      if (auto_clr || sw_clr)
        armed_q <= 1'b0;
      else if (csr_rd && flag_o)
        armed_q <= 1'b1;

      if (csr_wr) begin
        mode_o <= wr_byte[6];
        en_o   <= wr_byte[5];
        rate_o <= wr_byte[2:0];
      end
    end
  end
endmodule

// File: rtl/wdog_itimer.sv
module wdog_itimer
  import wdog_pkg::*;
#(
  parameter int   CNT_W      = 8,
  parameter bit   RST_REQ_EN = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        addr,
  input  logic [15:0] wdata,
  input  logic        wr_en,
  input  logic        rd_en,
  output logic [7:0]  rdata,
  output logic        irq_o,
  output logic        wdt_ovf_o,
  output logic        rst_req_o
);
  logic             tick;
  logic             wrap;
  logic             ovf_flag, mode_q, en_q;
  logic [2:0]       rate_q;
  logic [7:0]       csr_val;
  logic [CNT_W-1:0] cnt_q;
  logic             csr_wr, cnt_wr, csr_rd;

  assign csr_wr = wr_en & ~addr & (wdata[15:8] == KEY_CSR);
  assign cnt_wr = wr_en &  addr & (wdata[15:8] == KEY_CNT);
  assign csr_rd = rd_en & ~addr;

  wdog_prescaler #(.W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .rate(rate_q), .tick(tick)
  );

  wdog_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .en(en_q), .ld(cnt_wr),
    .ld_val(wdata[CNT_W-1:0]), .tick(tick), .cnt_o(cnt_q), .wrap_o(wrap)
  );

  wdog_csr u_csr (
    .clk(clk), .rst(rst), .csr_rd(csr_rd), .csr_wr(csr_wr),
    .wr_byte(wdata[7:0]), .wrap(wrap), .auto_clr(rst_req_o),
    .flag_o(ovf_flag), .mode_o(mode_q), .en_o(en_q), .rate_o(rate_q),
    .csr_val(csr_val)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata     <= 8'h00;
      irq_o     <= 1'b0;
      wdt_ovf_o <= 1'b0;
      rst_req_o <= 1'b0;
    end else begin
      if (rd_en)
        rdata <= addr ? 8'(cnt_q) : csr_val;
      irq_o     <= ovf_flag & ~mode_q;
      wdt_ovf_o <= wrap & mode_q;
      rst_req_o <= wrap & mode_q & RST_REQ_EN;
    end
  end
endmodule

// File: rtl/wdog_itimer_chk.sv
module wdog_itimer_chk #(
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             addr,
  input logic [15:0]      wdata,
  input logic             wr_en,
  input logic             ovf_flag,
  input logic             mode_q,
  input logic             en_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             wdt_ovf_o,
  input logic             rst_req_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  assert_ctl_keyed_R2: assert property (@(posedge clk) disable iff (rst)
    !(wr_en && !addr && wdata[15:8] == 8'hA5) |=> $stable({mode_q, en_q}));

  assert_cnt_step_R3: assert property (@(posedge clk) disable iff (rst)
    (en_q && !(wr_en && addr && wdata[15:8] == 8'h5A)) |=>
      (cnt_q == $past(cnt_q) || cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  assert_hold_zero_R4: assert property (@(posedge clk) disable iff (rst)
    !en_q |=> cnt_q == '0);

  assert_flag_set_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(ovf_flag) |-> ($past(cnt_q) == CNT_MAX && cnt_q == '0));

  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    $fell(ovf_flag) |-> ($past(rst_req_o) ||
      $past(wr_en && !addr && wdata[15:8] == 8'hA5 && !wdata[7])));

  assert_pulse_width_R9: assert property (@(posedge clk) disable iff (rst)
    wdt_ovf_o |=> !wdt_ovf_o);

  assert_req_with_ovf_R10: assert property (@(posedge clk) disable iff (rst)
    rst_req_o |-> wdt_ovf_o);
endmodule

bind wdog_itimer wdog_itimer_chk #(.CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
  .ovf_flag(ovf_flag), .mode_q(mode_q), .en_q(en_q), .cnt_q(cnt_q),
  .wdt_ovf_o(wdt_ovf_o), .rst_req_o(rst_req_o)
);

// File: tb/wdog_itimer_bench.sv
`timescale 1ns/1ps
module wdog_itimer_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        addr = 1'b0;
  logic [15:0] wdata = 16'h0;
  logic        wr_en = 1'b0;
  logic        rd_en = 1'b0;
  logic [7:0]  rdata;
  logic        irq_o, wdt_ovf_o, rst_req_o;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;
  string req = "R1";

  always #10 clk = ~clk;

  wdog_itimer u_wdog_itimer (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .rdata(rdata), .irq_o(irq_o), .wdt_ovf_o(wdt_ovf_o),
    .rst_req_o(rst_req_o)
  );

  // behavioural reference model
  int m_pre, m_prev, m_cnt, m_flag, m_mode, m_en, m_rate, m_arm;
  int m_irq, m_wdt, m_rst, m_rdata;

  function automatic int divisor(int code);
    case (code)
      0: return 2;      1: return 64;     2: return 128;   3: return 512;
      4: return 2048;   5: return 8192;   6: return 32768; default: return 131072;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_pre = 0; m_prev = 0; m_cnt = 0; m_flag = 0; m_mode = 0; m_en = 0;
      m_rate = 0; m_arm = 0; m_irq = 0; m_wdt = 0; m_rst = 0; m_rdata = 0;
    end else begin
      int bitv, tick, cw, sw, wrp, clr, nf, na, ncnt;
      bitv = (m_pre >> ($clog2(divisor(m_rate)) - 1)) & 1;
      tick = (bitv == 1 && m_prev == 0);
      cw   = wr_en && addr && wdata[15:8] == 8'h5A;
      sw   = wr_en && !addr && wdata[15:8] == 8'hA5;
      wrp  = m_en && tick && !cw && m_cnt == 255;
      if (!m_en) ncnt = 0;
      else if (cw) ncnt = wdata[7:0];
      else if (tick) ncnt = (m_cnt + 1) % 256;
      else ncnt = m_cnt;
      if (rd_en) m_rdata = addr ? m_cnt : (m_flag*128 + m_mode*64 + m_en*32 + 24 + m_rate);
      clr = sw && !wdata[7] && m_arm;
      nf  = wrp ? 1 : ((m_rst || clr) ? 0 : m_flag);
      na  = (m_rst || clr) ? 0 : ((rd_en && !addr && m_flag) ? 1 : m_arm);
      m_irq = m_flag && !m_mode;
      m_wdt = wrp && m_mode;
      m_rst = wrp && m_mode;
      if (sw) begin m_mode = wdata[6]; m_en = wdata[5]; m_rate = wdata[2:0]; end
      m_flag = nf; m_arm = na; m_cnt = ncnt; m_prev = bitv;
      m_pre = (m_pre + 1) % 131072;
    end
  end

  task automatic check(string r, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", r, what, act, exp);
    end
  endtask

  // compare every output with the model on every clock, away from the edge
  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      check(req, "irq_o", irq_o, m_irq);
      check(req, "wdt_ovf_o", wdt_ovf_o, m_wdt);
      check(req, "rst_req_o", rst_req_o, m_rst);
      check(req, "rdata", rdata, m_rdata);
    end
  end

  task automatic wr(logic a, logic [15:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic a, output logic [7:0] v);
    addr = a; rd_en = 1'b1;
    @(negedge clk);
    rd_en = 1'b0;
    v = rdata;
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    fails++; checks++;
    $display("FAIL watchdog expired: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : stim
    logic [7:0] v, last;
    int gap;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1", "irq/wdt/rst", {irq_o, wdt_ovf_o, rst_req_o}, 0);
    rd(1'b0, v); check("R1", "csr", v, 8'h18);
    rd(1'b1, v); check("R1", "cnt", v, 8'h00);

    // R2 key protection and layout
    req = "R2";
    wr(1'b0, 16'h0027); rd(1'b0, v); check("R2", "bad key csr", v, 8'h18);
    wr(1'b0, 16'hA525); rd(1'b0, v); check("R2", "csr write", v, 8'h3D);
    wr(1'b0, 16'hA500); rd(1'b0, v); check("R2", "csr stop", v, 8'h18);

    // R3 counter load, bad key, load while disabled
    req = "R3";
    wr(1'b1, 16'h5A77); rd(1'b1, v); check("R3", "load while disabled", v, 8'h00);
    wr(1'b0, 16'hA527);               // enabled, slowest rate: no ticks soon
    wr(1'b1, 16'h5A42); rd(1'b1, v); check("R3", "keyed load", v, 8'h42);
    wr(1'b1, 16'h1299); rd(1'b1, v); check("R3", "bad key load", v, 8'h42);

    // R4 disable forces zero and holds
    req = "R4";
    wr(1'b0, 16'hA507); @(negedge clk);
    rd(1'b1, v); check("R4", "forced zero", v, 8'h00);
    repeat (20) @(negedge clk);
    rd(1'b1, v); check("R4", "held zero", v, 8'h00);

    // R5 rate codes: measure increment spacing while polling every cycle
    req = "R5";
    for (int k = 0; k < 6; k++) begin
      wr(1'b0, 16'hA500);
      wr(1'b0, 16'hA520 | 16'(k));
      addr = 1'b1; rd_en = 1'b1;
      @(negedge clk); last = rdata;
      while (rdata == last) @(negedge clk);
      last = rdata;
      while (rdata == last) @(negedge clk);
      last = rdata; gap = 0;
      while (rdata == last) begin @(negedge clk); gap++; end
      rd_en = 1'b0;
      check("R5", $sformatf("spacing code %0d", k), gap, divisor(k));
    end

    // R6/R8 interval overflow
    req = "R6";
    wr(1'b0, 16'hA520);
    wr(1'b1, 16'h5AFE);
    while (!irq_o) @(negedge clk);
    req = "R8";
    check("R8", "irq level", irq_o, 1);
    // R7 write zero without prior read: no clear
    req = "R7";
    wr(1'b0, 16'hA500); @(negedge clk);
    check("R7", "irq after unarmed clear", irq_o, 1);
    rd(1'b0, v); check("R7", "flag kept", v, 8'h98);
    wr(1'b0, 16'hA580); rd(1'b0, v); check("R7", "write one no effect", v, 8'h98);
    wr(1'b0, 16'hA500); rd(1'b0, v); check("R7", "armed clear", v, 8'h18);
    @(negedge clk);
    check("R8", "irq dropped", irq_o, 0);

    // R9/R10 watchdog overflow pulse and auto clear
    req = "R9";
    wr(1'b0, 16'hA560);
    wr(1'b1, 16'h5AFC);
    while (!wdt_ovf_o) @(negedge clk);
    check("R10", "reset request with overflow", rst_req_o, 1);
    check("R9", "no irq in watchdog", irq_o, 0);
    @(negedge clk);
    check("R9", "pulse one wide", wdt_ovf_o, 0);
    req = "R10";
    rd(1'b0, v); check("R10", "flag auto cleared", v, 8'h78);
    repeat (10) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule